// File: doc/BRIEF.md
# Clocked Synchronous Serial Receiver

This block takes in 8-bit frames over a clocked synchronous serial link. Each bit on the data line is captured on a rising edge of the serial clock, least significant bit first. The block can generate the serial clock itself by dividing the system clock, or it can take the clock from an external pin. When the eighth bit arrives, the assembled byte moves into a holding register. At that point a ready flag sets and, if enabled, an interrupt request is raised.

Software reads the byte and writes a 0 to the ready flag before the next frame's last bit lands. If it does not, the block records an overrun. The overrunning byte is discarded and all serial activity freezes until software clears the overrun flag. In generated-clock mode the serial clock stops during this freeze. A deliberate dummy byte that causes an overrun can therefore be used to pause the link. Two error inputs carried over from asynchronous operation (parity and framing) also freeze the block while either one is high. An inhibit output tells the neighbouring transmitter when it must hold off.

Top module: `sync_rx`

## Requirements
- R1: After reset, `rdrf`, `orer`, `rx_irq` and `tx_inhibit` are 0, `rd_data` is 0 and `sck_out` is 1.
- R2: Bits are captured least significant first, one per serial clock rising edge. After the eighth edge the byte appears on `rd_data` and `rdrf` becomes 1.
- R3: `rx_irq` is 1 exactly when `rdrf` is 1 and `irq_en` is 1.
- R4: A write with `st_wr` clears `rdrf` when `st_wdata[0]` is 0 and clears `orer` when `st_wdata[1]` is 0. A 1 in either bit leaves that flag unchanged.
- R5: If a frame completes while `rdrf` is 1, `orer` becomes 1, `rd_data` keeps the unread byte and the new byte is lost. `rd_data` never changes while `rdrf` is 1.
- R6: While `orer` is 1, no bit is captured and `tx_inhibit` is 1. After `orer` is cleared, the next full frame is received correctly.
- R7: While `par_err` or `frm_err` is 1, no bit is captured, `rdrf` is never set and `tx_inhibit` is 1.
- R8: With `clk_out_mode` = 1, `sck_out` toggles every `div_half`+1 system clocks while `rx_en` is 1 and no blocking flag is set. The serial period is therefore 2*(`div_half`+1) clocks. Otherwise `sck_out` is held at 1.
- R9: Dropping `rx_en` mid-frame discards the partial frame, so the next enable starts again at bit 0.
- R10: With `clk_out_mode` = 0, `sck_in` and `rxd` each pass through a two-stage synchronizer. A rising edge of the synchronized clock captures the synchronized data, and `sck_out` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive enable; low discards any partial frame |
| clk_out_mode | input | 1 | 1: generate the serial clock internally; 0: use `sck_in` |
| div_half | input | DIVW | Serial half-period in system clocks, minus one |
| sck_in | input | 1 | External serial clock |
| rxd | input | 1 | Serial data |
| st_wr | input | 1 | Status write strobe |
| st_wdata | input | 2 | Bit 0: ready flag, bit 1: overrun flag; a 0 clears the flag, a 1 is ignored |
| par_err | input | 1 | Parity-error flag carried over from async mode (blocking) |
| frm_err | input | 1 | Framing-error flag carried over from async mode (blocking) |
| irq_en | input | 1 | Receive interrupt enable |
| sck_out | output | 1 | Generated serial clock, idle high |
| rd_data | output | DATAW | Received byte register |
| rdrf | output | 1 | Receive data ready flag |
| orer | output | 1 | Overrun flag |
| rx_irq | output | 1 | Receive interrupt request |
| tx_inhibit | output | 1 | Transmit must hold off (overrun or blocking error) |

## Verification
A wrong bit counter shows up as a byte that is shifted or rotated on `rd_data` at the end of the very first frame. A counter that survives a disable shows up in the first frame after a re-enable. Incorrect overrun handling becomes visible within one frame time. It appears as a changed `rd_data` while `rdrf` is held, as `orer` staying low, or as `sck_out` still toggling during the freeze. A divider fault changes the measured serial period from the first cycle. A missing synchronizer stage only shows as lost or early bits when the external clock phases are short.

// File: rtl/sync_rx.sv
module sync_rx #(
  parameter int DIVW  = 8,
  parameter int DATAW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             clk_out_mode,
  input  logic [DIVW-1:0]  div_half,
  input  logic             sck_in,
  input  logic             rxd,
  input  logic             st_wr,
  input  logic [1:0]       st_wdata,
  input  logic             par_err,
  input  logic             frm_err,
  input  logic             irq_en,
  output logic             sck_out,
  output logic [DATAW-1:0] rd_data,
  output logic             rdrf,
  output logic             orer,
  output logic             rx_irq,
  output logic             tx_inhibit
);
  localparam int CNTW = (DATAW > 1) ? $clog2(DATAW) : 1;
  localparam logic [CNTW-1:0] LAST_BIT = CNTW'(DATAW - 1);

  logic [2:0]       sck_sy;
  logic [1:0]       rxd_sy;
  logic [DIVW-1:0]  dcnt;
  logic [CNTW-1:0]  bcnt;
  logic [DATAW-1:0] shreg;

  wire blocked  = orer | par_err | frm_err;
  wire run      = rx_en & ~blocked;
  wire half_end = (dcnt == div_half);
  wire int_rise = run & clk_out_mode & half_end & ~sck_out;
  wire ext_rise = run & ~clk_out_mode & sck_sy[1] & ~sck_sy[2];
  wire sample   = int_rise | ext_rise;
  wire bit_in   = clk_out_mode ? rxd : rxd_sy[1];
  wire last     = sample & (bcnt == LAST_BIT);
  wire [DATAW-1:0] frame = {bit_in, shreg[DATAW-1:1]};

  assign tx_inhibit = blocked;
  assign rx_irq     = rdrf & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_sy <= 3'b111;
      rxd_sy <= 2'b11;
    end else begin
      sck_sy <= {sck_sy[1:0], sck_in};
      rxd_sy <= {rxd_sy[0], rxd};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run || !clk_out_mode) begin
      dcnt    <= '0;
      sck_out <= 1'b1;
    end else if (half_end) begin
      dcnt    <= '0;
      sck_out <= ~sck_out;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en) begin
      bcnt  <= '0;
      shreg <= '0;
    end else if (sample) begin
      shreg <= frame;
      bcnt  <= last ? '0 : bcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdrf    <= 1'b0;
      orer    <= 1'b0;
      rd_data <= '0;
    end else begin
      if (last && !rdrf) begin
        rdrf    <= 1'b1;
        rd_data <= frame;
      end else if (st_wr && !st_wdata[0]) begin
        rdrf <= 1'b0;
      end
      if (last && rdrf)
        orer <= 1'b1;
      else if (st_wr && !st_wdata[1])
        orer <= 1'b0;
    end
  end

  a_r5_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    rdrf |=> $stable(rd_data));

  a_r6_orer_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (orer && !(st_wr && !st_wdata[1])) |=> orer);

  a_r6_clock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    orer |=> sck_out);

  a_r7_no_ready_when_err: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err || frm_err) |=> !$rose(rdrf));

  a_r3_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rdrf);

  a_r9_disable_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (bcnt == '0));

  a_r10_ext_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_out_mode |=> sck_out);
endmodule

// File: tb/sync_rx_test.sv
module sync_rx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, clk_out_mode = 1'b1, sck_in = 1'b1, rxd = 1'b1;
  logic st_wr = 1'b0, par_err = 1'b0, frm_err = 1'b0, irq_en = 1'b1;
  logic [1:0] st_wdata = 2'b11;
  logic [7:0] div_half = 8'd1;
  logic sck_out, rdrf, orer, rx_irq, tx_inhibit;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  int cyc = 0;

  sync_rx #(.DIVW(8), .DATAW(8)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_out_mode(clk_out_mode),
    .div_half(div_half), .sck_in(sck_in), .rxd(rxd), .st_wr(st_wr),
    .st_wdata(st_wdata), .par_err(par_err), .frm_err(frm_err), .irq_en(irq_en),
    .sck_out(sck_out), .rd_data(rd_data), .rdrf(rdrf), .orer(orer),
    .rx_irq(rx_irq), .tx_inhibit(tx_inhibit));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model_period(input logic [7:0] d);
    return 2 * (int'(d) + 1);
  endfunction

  function automatic logic model_irq(input logic ready, input logic en);
    return ready & en;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr_stat(input logic [1:0] v);
    st_wr = 1'b1;
    st_wdata = v;
    tick(1);
    st_wr = 1'b0;
    st_wdata = 2'b11;
  endtask

  task automatic send_int(input logic [7:0] b, input int nbits);
    clk_out_mode = 1'b1;
    rx_en = 1'b1;
    for (int i = 0; i < nbits; i++) begin
      @(negedge sck_out);
      #1 rxd = b[i];
      @(posedge sck_out);
    end
    #1 rx_en = 1'b0;
    tick(2);
  endtask

  task automatic send_ext(input logic [7:0] b);
    clk_out_mode = 1'b0;
    rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      sck_in = 1'b0;
      rxd = b[i];
      tick(3);
      sck_in = 1'b1;
      tick(3);
      chk("R10 sck_out idle in external mode", sck_out, 1);
    end
    tick(4);
    rx_en = 1'b0;
    tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [7:0] d;
    int t0;
    tick(3);
    chk("R1 rdrf", rdrf, 0);
    chk("R1 orer", orer, 0);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 tx_inhibit", tx_inhibit, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 sck_out", sck_out, 1);
    rst_n = 1'b1;
    tick(2);

    send_int(8'hA5, 8);
    chk("R2 byte lsb first", rd_data, 8'hA5);
    chk("R2 ready set", rdrf, 1);
    chk("R3 irq with enable", rx_irq, model_irq(rdrf, irq_en));
    irq_en = 1'b0;
    tick(1);
    chk("R3 irq masked", rx_irq, 0);
    irq_en = 1'b1;

    wr_stat(2'b11);
    chk("R4 write 1 ignored rdrf", rdrf, 1);
    chk("R4 write 1 ignored orer", orer, 0);
    wr_stat(2'b10);
    chk("R4 write 0 clears rdrf", rdrf, 0);

    send_int(8'h3C, 8);
    send_int(8'hC3, 8);
    chk("R5 overrun flagged", orer, 1);
    chk("R5 old byte kept", rd_data, 8'h3C);
    chk("R5 ready stays", rdrf, 1);
    chk("R6 tx inhibit", tx_inhibit, 1);
    rx_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick(10);
      chk("R6 clock frozen during overrun", sck_out, 1);
    end
    rx_en = 1'b0;
    wr_stat(2'b00);
    chk("R6 orer cleared", orer, 0);
    chk("R6 inhibit released", tx_inhibit, 0);
    send_int(8'h5A, 8);
    chk("R6 resume receive", rd_data, 8'h5A);
    wr_stat(2'b10);

    for (int k = 0; k < 3; k++) begin
      div_half = 8'(k * 3);
      rx_en = 1'b1;
      @(posedge sck_out);
      t0 = cyc;
      @(posedge sck_out);
      #1 chk("R8 serial period", cyc - t0, model_period(div_half));
      rx_en = 1'b0;
      tick(2);
    end
    div_half = 8'd1;

    send_int(8'hFF, 3);
    chk("R9 partial frame no ready", rdrf, 0);
    send_int(8'h96, 8);
    chk("R9 restart at bit 0", rd_data, 8'h96);
    wr_stat(2'b10);

    par_err = 1'b1;
    rx_en = 1'b1;
    tick(30);
    chk("R7 no clock with parity err", sck_out, 1);
    chk("R7 inhibit", tx_inhibit, 1);
    rx_en = 1'b0;
    send_ext(8'h77);
    chk("R7 no ready with parity err", rdrf, 0);
    par_err = 1'b0;
    frm_err = 1'b1;
    send_ext(8'h11);
    chk("R7 no ready with framing err", rdrf, 0);
    frm_err = 1'b0;
    send_ext(8'h81);
    chk("R10 external byte", rd_data, 8'h81);
    chk("R10 external ready", rdrf, 1);
    wr_stat(2'b10);

    void'($urandom(32'h5eed));
    for (int k = 0; k < 24; k++) begin
      b = 8'($urandom);
      d = 8'($urandom_range(0, 3));
      div_half = d;
      irq_en = 1'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        send_int(b, 8);
        chk("R2 random internal", rd_data, b);
      end else begin
        send_ext(b);
        chk("R10 random external", rd_data, b);
      end
      chk("R3 random irq", rx_irq, model_irq(1'b1, irq_en));
      wr_stat(2'b10);
      chk("R4 random clear", rdrf, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule